// File: doc/BRIEF.md
# Receive Message Queue with Watermark and Full Policy

This block holds received frames for a CAN controller in a circular queue of fixed-size elements. The protocol engine hands over one whole element per cycle on a push port. The host side sees the current fill level, the slot index of the oldest unread element and a read port that returns the element stored in any slot. The host frees slots by naming the last slot it has consumed. Every slot from the oldest one up to the named slot is then released.

Two independent sticky notifications tell the host that work is waiting. One is raised for every stored element. The other is raised when the fill level reaches a programmable threshold. Messages below the threshold only show up in the fill level, which the host has to poll. When the queue is full, a policy input decides what happens to an incoming element. Either it is dropped, or it replaces the oldest element. In both cases a loss flag records that a message went missing. Each flag stays set until the host clears it through a clear vector. A set in the same cycle wins over a clear.

Top module: `rxq_fifo`

## Requirements
- R1: While reset is active, and after it, the fill level is 0, the get index is 0, full is 0 and all three flags are 0.
- R2: An accepted push writes its element into slot (get_idx + fill_level) mod DEPTH and raises the fill level by one. Driving that slot number on rd_idx returns the element on rd_data.
- R3: new_msg_flag is set by every push that stores an element. It stays set until a cycle with flag_clr bit 0 high and no new store in that same cycle.
- R4: wm_flag is set in the cycle the fill level changes from a value other than cfg_wm_level to cfg_wm_level. A cfg_wm_level of 0 never sets it. flag_clr bit 1 clears it.
- R5: full is 1 exactly when the fill level equals DEPTH, and the fill level never goes above DEPTH.
- R6: With cfg_overwrite = 0, a push that meets a full queue is dropped. The stored elements, the get index and the fill level stay as they were.
- R7: With cfg_overwrite = 1, a push that meets a full queue writes over the oldest slot. The get index advances by one and the fill level stays at DEPTH.
- R8: lost_flag is set by any push that meets a full queue, in either policy. flag_clr bit 2 clears it.
- R9: An acknowledge with ack_idx releases all slots from get_idx through ack_idx inclusive, counted modulo DEPTH. The get index moves to ack_idx + 1 and the fill level drops by the number of slots released.
- R10: An acknowledge whose ack_idx is not an occupied slot (modulo distance from get_idx at least the fill level) is ignored.
- R11: When an acknowledge and a push arrive in the same cycle, the release is applied first. The push therefore sees the space just freed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| push_valid | input | 1 | Protocol engine offers one element |
| push_data | input | ELEM_W | Element contents |
| cfg_overwrite | input | 1 | Full-queue policy: 1 overwrites oldest, 0 drops incoming |
| cfg_wm_level | input | IDX_W+1 | Watermark threshold, 0 disables |
| ack_valid | input | 1 | Host acknowledge strobe |
| ack_idx | input | IDX_W | Last slot consumed by the host |
| flag_clr | input | 3 | Flag clear: bit 0 new, bit 1 watermark, bit 2 lost |
| rd_idx | input | IDX_W | Slot to read |
| rd_data | output | ELEM_W | Element stored in slot rd_idx |
| fill_level | output | IDX_W+1 | Number of occupied slots |
| get_idx | output | IDX_W | Slot of the oldest element |
| full | output | 1 | Fill level equals DEPTH |
| new_msg_flag | output | 1 | Sticky: an element was stored |
| wm_flag | output | 1 | Sticky: fill level reached the threshold |
| lost_flag | output | 1 | Sticky: a message was dropped or overwritten |

## Verification
The bench runs both full-queue policies against every watermark threshold from 0 to DEPTH on a four-slot queue. In each run it pushes past capacity, so that the fill transitions, the watermark edge and the drop or overwrite behaviour are all seen at every level. Single-slot and multi-slot acknowledges check the wrap of the get index. An acknowledge that names an empty slot checks that invalid releases are refused. A push issued together with an acknowledge into a full queue shows whether the release is ordered first. Flag clears issued alone and together with a new event check that set wins over clear.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int NUM_FLAGS = 3;
  typedef enum int unsigned {
    FLG_NEW  = 0,
    FLG_WM   = 1,
    FLG_LOST = 2
  } flag_pos_e;
endpackage

// File: rtl/rxq_ptr_ctrl.sv
module rxq_ptr_ctrl #(
  parameter int IDX_W = 3,
  localparam int CNT_W = IDX_W + 1,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_valid,
  input  logic             cfg_overwrite,
  input  logic [CNT_W-1:0] cfg_wm_level,
  input  logic             ack_valid,
  input  logic [IDX_W-1:0] ack_idx,
  output logic [IDX_W-1:0] get_idx,
  output logic [CNT_W-1:0] fill_level,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_addr,
  output logic             ev_new,
  output logic             ev_wm,
  output logic             ev_lost
);
  logic [IDX_W-1:0] get_q, get_d, get_a, rel_dist;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_a, rel_cnt;
  logic             ack_ok, full_a, store, drop_or_over, over;

  // release stage: validate the acknowledge against the occupied range
  always_comb begin
    rel_dist = ack_idx - get_q;
    rel_cnt  = {1'b0, rel_dist} + CNT_W'(1);
    ack_ok   = ack_valid && (rel_cnt <= cnt_q);
    cnt_a    = ack_ok ? (cnt_q - rel_cnt) : cnt_q;
    get_a    = ack_ok ? (get_q + rel_cnt[IDX_W-1:0]) : get_q;
    full_a   = (cnt_a == CNT_W'(DEPTH));
  end

  // push stage: operates on the post-release state
  always_comb begin
    drop_or_over = push_valid && full_a;
    over         = drop_or_over && cfg_overwrite;
    store        = push_valid && (!full_a || cfg_overwrite);
    wr_en        = store;
    wr_addr      = get_a + cnt_a[IDX_W-1:0];
    cnt_d        = (store && !full_a) ? (cnt_a + CNT_W'(1)) : cnt_a;
    get_d        = over ? (get_a + IDX_W'(1)) : get_a;
    ev_new       = store;
    ev_lost      = drop_or_over;
    ev_wm        = (cfg_wm_level != '0) && (cnt_d == cfg_wm_level) &&
                   (cnt_q != cfg_wm_level);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      get_q <= '0;
      cnt_q <= '0;
    end else begin
      get_q <= get_d;
      cnt_q <= cnt_d;
    end
  end

  assign get_idx    = get_q;
  assign fill_level = cnt_q;
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int IDX_W  = 3,
  parameter int ELEM_W = 32,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [ELEM_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [ELEM_W-1:0] rd_data
);
  logic [ELEM_W-1:0] slot_q [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic slot_we;
    assign slot_we = wr_en && (wr_addr == IDX_W'(s));
    always_ff @(posedge clk) begin
      if (slot_we) slot_q[s] <= wr_data;
    end
  end

  assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/rxq_flags.sv
module rxq_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  for (genvar f = 0; f < N; f++) begin : g_flag
    logic q, d;
    always_comb begin
      d = q;
      if (clr[f]) d = 1'b0;
      if (set[f]) d = 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= d;
    end
    assign flags[f] = q;
  end
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
  parameter int IDX_W  = 3,
  parameter int ELEM_W = 32,
  localparam int CNT_W = IDX_W + 1,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  logic [ELEM_W-1:0] push_data,
  input  logic              cfg_overwrite,
  input  logic [CNT_W-1:0]  cfg_wm_level,
  input  logic              ack_valid,
  input  logic [IDX_W-1:0]  ack_idx,
  input  logic [2:0]        flag_clr,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [ELEM_W-1:0] rd_data,
  output logic [CNT_W-1:0]  fill_level,
  output logic [IDX_W-1:0]  get_idx,
  output logic              full,
  output logic              new_msg_flag,
  output logic              wm_flag,
  output logic              lost_flag
);
  import rxq_pkg::*;

  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  logic                 wr_en, ev_new, ev_wm, ev_lost;
  logic [IDX_W-1:0]     wr_addr;
  logic [NUM_FLAGS-1:0] flag_set, flag_q;

  rxq_ptr_ctrl #(.IDX_W(IDX_W)) u_ptr (
    .clk(clk), .rst_n(rst_s_n), .push_valid(push_valid),
    .cfg_overwrite(cfg_overwrite), .cfg_wm_level(cfg_wm_level),
    .ack_valid(ack_valid), .ack_idx(ack_idx), .get_idx(get_idx),
    .fill_level(fill_level), .wr_en(wr_en), .wr_addr(wr_addr),
    .ev_new(ev_new), .ev_wm(ev_wm), .ev_lost(ev_lost)
  );

  rxq_store #(.IDX_W(IDX_W), .ELEM_W(ELEM_W)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(push_data),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  always_comb begin
    flag_set           = '0;
    flag_set[FLG_NEW]  = ev_new;
    flag_set[FLG_WM]   = ev_wm;
    flag_set[FLG_LOST] = ev_lost;
  end

  rxq_flags #(.N(NUM_FLAGS)) u_flags (
    .clk(clk), .rst_n(rst_s_n), .set(flag_set), .clr(flag_clr),
    .flags(flag_q)
  );

  assign new_msg_flag = flag_q[FLG_NEW];
  assign wm_flag      = flag_q[FLG_WM];
  assign lost_flag    = flag_q[FLG_LOST];
  assign full         = (fill_level == CNT_W'(DEPTH));
endmodule

// File: rtl/rxq_fifo_chk.sv
module rxq_fifo_chk #(
  parameter int IDX_W = 3,
  localparam int CNT_W = IDX_W + 1,
  localparam int DEPTH = 1 << IDX_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push_valid,
  input logic             cfg_overwrite,
  input logic [CNT_W-1:0] cfg_wm_level,
  input logic             ack_valid,
  input logic [CNT_W-1:0] fill_level,
  input logic [IDX_W-1:0] get_idx,
  input logic             full,
  input logic             new_msg_flag,
  input logic             wm_flag,
  input logic             lost_flag
);
  assert_fill_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= CNT_W'(DEPTH));

  assert_store_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !full && !ack_valid) |=>
      (fill_level == CNT_W'($past(fill_level) + 1'b1)) && new_msg_flag);

  assert_drop_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && full && !cfg_overwrite && !ack_valid) |=>
      (fill_level == CNT_W'(DEPTH)) && $stable(get_idx) && lost_flag);

  assert_overwrite_oldest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && full && cfg_overwrite && !ack_valid) |=>
      (fill_level == CNT_W'(DEPTH)) &&
      (get_idx == IDX_W'($past(get_idx) + 1'b1)) && lost_flag);

  assert_wm_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wm_flag) |->
      ($past(cfg_wm_level) != '0) && (fill_level == $past(cfg_wm_level)));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_valid && !ack_valid) |=> $stable(fill_level) && $stable(get_idx));
endmodule

bind rxq_fifo rxq_fifo_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_s_n), .push_valid(push_valid),
  .cfg_overwrite(cfg_overwrite), .cfg_wm_level(cfg_wm_level),
  .ack_valid(ack_valid), .fill_level(fill_level), .get_idx(get_idx),
  .full(full), .new_msg_flag(new_msg_flag), .wm_flag(wm_flag),
  .lost_flag(lost_flag)
);

// File: tb/rxq_fifo_test.sv
module rxq_fifo_test;
  localparam int IDX_W = 2;
  localparam int ELEM_W = 8;
  localparam int D = 1 << IDX_W;

  logic clk = 1'b0;
  always #5ns clk = ~clk;

  logic              rst_n, push_valid, cfg_overwrite, ack_valid;
  logic [ELEM_W-1:0] push_data, rd_data;
  logic [IDX_W:0]    cfg_wm_level, fill_level;
  logic [IDX_W-1:0]  ack_idx, rd_idx, get_idx;
  logic [2:0]        flag_clr;
  logic              full, new_msg_flag, wm_flag, lost_flag;

  rxq_fifo #(.IDX_W(IDX_W), .ELEM_W(ELEM_W)) uut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
    .cfg_overwrite(cfg_overwrite), .cfg_wm_level(cfg_wm_level),
    .ack_valid(ack_valid), .ack_idx(ack_idx), .flag_clr(flag_clr),
    .rd_idx(rd_idx), .rd_data(rd_data), .fill_level(fill_level),
    .get_idx(get_idx), .full(full), .new_msg_flag(new_msg_flag),
    .wm_flag(wm_flag), .lost_flag(lost_flag)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  int mslot [D];
  int mget, mcnt, mode, wm;
  bit fnew, fwm, flost;

  task automatic chk(int act, int exp, string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(int'(fill_level), mcnt, {"R2/R9 fill ", tag});
    chk(int'(get_idx), mget, {"R9 get ", tag});
    chk(int'(full), int'(mcnt == D), {"R5 full ", tag});
    chk(int'(new_msg_flag), int'(fnew), {"R3 new ", tag});
    chk(int'(wm_flag), int'(fwm), {"R4 wm ", tag});
    chk(int'(lost_flag), int'(flost), {"R8 lost ", tag});
    for (int k = 0; k < mcnt; k++) begin
      rd_idx = IDX_W'((mget + k) % D);
      #1;
      chk(int'(rd_data), mslot[(mget + k) % D], {"R2/R7 data ", tag});
    end
  endtask

  // one cycle of stimulus, model update from the requirements, then checks
  task automatic cyc(bit p, int dat, bit a, int aidx, int clr, string tag);
    int prev, rel;
    bit sn, sw, sl;
    push_valid = p; push_data = ELEM_W'(dat);
    ack_valid = a; ack_idx = IDX_W'(aidx); flag_clr = 3'(clr);
    prev = mcnt; sn = 0; sw = 0; sl = 0;
    rel = ((aidx - mget) % D + D) % D + 1;
    if (a && rel <= mcnt) begin
      mget = (mget + rel) % D;
      mcnt -= rel;
    end
    if (p) begin
      if (mcnt < D) begin
        mslot[(mget + mcnt) % D] = dat; mcnt++; sn = 1;
      end else begin
        sl = 1;
        if (mode == 1) begin
          mslot[mget] = dat; mget = (mget + 1) % D; sn = 1;
        end
      end
    end
    if (wm != 0 && mcnt == wm && prev != wm) sw = 1;
    fnew  = sn ? 1'b1 : (clr[0] ? 1'b0 : fnew);
    fwm   = sw ? 1'b1 : (clr[1] ? 1'b0 : fwm);
    flost = sl ? 1'b1 : (clr[2] ? 1'b0 : flost);
    @(posedge clk); #1;
    push_valid = 0; ack_valid = 0; flag_clr = 0;
    check_all(tag);
  endtask

  task automatic do_reset();
    rst_n = 0; push_valid = 0; ack_valid = 0; flag_clr = 0;
    push_data = 0; ack_idx = 0; rd_idx = 0;
    cfg_overwrite = 1'(mode); cfg_wm_level = (IDX_W+1)'(wm);
    mget = 0; mcnt = 0; fnew = 0; fwm = 0; flost = 0;
    repeat (2) @(posedge clk);
    #1;
    check_all("R1 in reset");
    rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    mode = 0; wm = 0;
    do_reset();
    check_all("R1 after reset");
    for (int m = 0; m < 2; m++) begin
      for (int w = 0; w <= D; w++) begin
        mode = m; wm = w;
        do_reset();
        // fill past capacity: R6/R7 policy, R4 edge, R8 loss
        for (int i = 0; i < D + 2; i++)
          cyc(1, 16*m + 4*w + i + 1, 0, 0, 0, m ? "R7 overfill" : "R6 overfill");
        // clear new and lost while idle (R3, R8)
        cyc(0, 0, 0, 0, 3'b101, "R3 R8 clear");
        // single acknowledges across the wrap point (R9)
        cyc(0, 0, 1, mget, 0, "R9 ack one");
        cyc(0, 0, 1, mget, 3'b010, "R9 ack one, R4 clear");
        // ack that names an unoccupied slot (R10)
        cyc(0, 0, 1, mget + mcnt, 0, "R10 bad ack");
        // release the rest in one acknowledge (R9)
        cyc(0, 0, 1, mget + mcnt - 1, 0, "R9 ack all");
        cyc(0, 0, 1, mget, 0, "R10 ack empty");
        // refill, then push with ack into a full queue (R11)
        for (int i = 0; i < D; i++)
          cyc(1, 100 + i, 0, 0, 0, "R2 refill");
        cyc(1, 200, 1, mget + 1, 3'b001, "R11 ack+push, R3 set wins");
        cyc(0, 0, 0, 0, 3'b111, "R3 R4 R8 clear all");
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000ns;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule